// File: doc/BRIEF.md
# VLAN Tag Receive Filter

This block watches the receive byte stream of an Ethernet frame and decides whether the frame carries an 802.1Q tag and whether that tag passes a programmed filter. It reads the two-byte type field that follows the destination and source addresses. If the type marks a tagged frame, it takes the 16-bit tag control information from the next two bytes. One cycle after the last tag byte arrives, it reports a tagged flag and a match flag together with a single-cycle valid pulse.

The filter has two modes. Exact compare tests the tag against a programmed value, and it can be inverted so that it passes every tag that differs from that value. Hash lookup computes a CRC of the tag, uses the top bits of that CRC as an index into a 16-bit table, and passes the frame if the table bit at that index is set. The compare or the hash can cover the full 16-bit tag or only the 12-bit VLAN identifier. Frames typed 0x88A8 can optionally be counted as tagged.

Software writes a control word and the hash table through a small write port. Each frame works from a copy of that configuration taken when the frame starts, so a write made while a frame is being parsed has no effect on the result for that frame.

Top module: `vlan_rx_filter`

## Requirements
- R1: After reset all outputs are 0 and both the control word and the hash table are 0. With this default configuration, a 0x8100 frame with tag 0x0000 reports tagged=1 and match=1.
- R2: Bytes 12 and 13 of a frame form the type field, high byte first, and the value 0x8100 always marks the frame as tagged. Bytes 14 and 15 form the tag, with byte 14 as the high byte.
- R3: A frame typed 0x88A8 counts as tagged only when control bit 18 is 1. Every other type gives tagged=0 and match=0 in all modes.
- R4: res_valid_o pulses high for exactly one cycle, in the cycle that follows the clock edge on which byte 15 is accepted. A frame shorter than 16 bytes produces no pulse. While res_valid_o is low, tagged_o and match_o are 0.
- R5: When bit 19 and bit 17 are both 0, a tagged frame matches if its tag equals control bits 15:0. When bit 16 is 1, only tag bits 11:0 are compared; when bit 16 is 0, all 16 bits are compared.
- R6: When bit 17 is 1 and bit 19 is 0, a tagged frame matches only if the compare of R5 fails.
- R7: When bit 19 is 1, the CRC-32 is computed over the tag high byte and then the tag low byte. It uses the reflected polynomial 0xEDB88320, starts from all ones and is complemented at the end. When bit 16 is 1, tag bits 15:12 are cleared before the CRC is computed. The final CRC bits 31:28 index the hash table, and a tagged frame matches if that table bit is 1. In this mode bit 17 has no effect.
- R8: A write with cfg_sel_i=0 loads the control word from cfg_wdata_i. A write with cfg_sel_i=1 loads the hash table from cfg_wdata_i[15:0].
- R9: Configuration is sampled on the cycle that accepts a frame-start byte. A write made in that same cycle, or at any later point in the same frame, does not change that frame's result.
- R10: A byte with sof_i=1 restarts byte counting at index 0, even in the middle of a frame. Cycles in which byte_valid_i is 0 do not advance the count. Frames may follow each other with no idle cycle, and bytes received before the first frame start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: control word, 1: hash table |
| cfg_wdata_i | input | 20 | Write data (control bits 19:0, or table bits 15:0) |
| sof_i | input | 1 | Marks the accepted byte as byte 0 of a frame |
| byte_valid_i | input | 1 | Byte accepted this cycle |
| byte_i | input | 8 | Frame byte |
| res_valid_o | output | 1 | One-cycle result pulse |
| tagged_o | output | 1 | Frame carries an accepted tag type |
| match_o | output | 1 | Tag passed the filter |

## Verification
The bench runs tagged frames through each mode and compares the result against a behavioural model on every clock:
- **Exact compare:** equal and unequal tags show that the equality test works. Tags that differ only in their top nibble show the difference between 12-bit and 16-bit compare.
- **Inverted compare:** the same pairs of tags show that inversion flips the exact-compare result.
- **Hash lookup:** a table holding only the computed index bit, and the complement of that table, show that the lookup reads the bit at the right position. Frames with 0x88A8 and 0x0800 types show that the type decode is kept separate from the filter.
- **Framing and timing:** short frames, frames with idle gaps, back-to-back frames, a restart in mid-frame and configuration writes during a frame show that framing and the per-frame configuration copy behave as R4, R9 and R10 require.

// File: rtl/vlan_filt_pkg.sv
package vlan_filt_pkg;

  typedef struct packed {
    logic        hash_en;
    logic        svlan_en;
    logic        inv_en;
    logic        vid_only;
    logic [15:0] tag;
  } vlan_cfg_t;

  localparam int CFG_W = $bits(vlan_cfg_t);
  localparam int TAG_W = 16;
  localparam int VID_W = 12;
  localparam logic [15:0] ETH_C_TAG = 16'h8100;
  localparam logic [15:0] ETH_S_TAG = 16'h88A8;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;

  function automatic logic [31:0] crc_byte(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] crc_tag(input logic [TAG_W-1:0] t);
    logic [31:0] c;
    c = crc_byte(32'hFFFF_FFFF, t[15:8]);
    c = crc_byte(c, t[7:0]);
    return ~c;
  endfunction

endpackage

// File: rtl/vlan_filt_cfg.sv
module vlan_filt_cfg
  import vlan_filt_pkg::*;
#(
  parameter int HASH_N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              snap_i,
  output vlan_cfg_t         act_cfg_o,
  output logic [HASH_N-1:0] act_hash_o
);

  vlan_cfg_t         shd_cfg_q;
  logic [HASH_N-1:0] shd_hash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_cfg_q  <= '0;
      shd_hash_q <= '0;
    end else if (we_i) begin
      if (sel_i) shd_hash_q <= wdata_i[HASH_N-1:0];
      else       shd_cfg_q  <= vlan_cfg_t'(wdata_i);
    end
  end

  // per-frame copy: uses the shadow value before any same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_cfg_o  <= '0;
      act_hash_o <= '0;
    end else if (snap_i) begin
      act_cfg_o  <= shd_cfg_q;
      act_hash_o <= shd_hash_q;
    end
  end

endmodule

// File: rtl/vlan_filt_parse.sv
module vlan_filt_parse #(
  parameter int TYPE_POS = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sof_i,
  input  logic        byte_valid_i,
  input  logic [7:0]  byte_i,
  output logic        frame_start_o,
  output logic        last_o,
  output logic [15:0] type_o,
  output logic [15:0] tag_o
);

  localparam int LAST_POS = TYPE_POS + 3;
  localparam int IDLE_POS = LAST_POS + 1;
  localparam int CNT_W    = $clog2(IDLE_POS + 1);

  logic [CNT_W-1:0] cnt_q, pos;
  logic [7:0]       tci_hi_q;

  assign pos           = sof_i ? '0 : cnt_q;
  assign frame_start_o = byte_valid_i && sof_i;
  assign last_o        = byte_valid_i && (pos == CNT_W'(LAST_POS));
  assign tag_o         = {tci_hi_q, byte_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= CNT_W'(IDLE_POS);
      type_o   <= '0;
      tci_hi_q <= '0;
    end else if (byte_valid_i && pos != CNT_W'(IDLE_POS)) begin
      cnt_q <= pos + 1'b1;
      if (pos == CNT_W'(TYPE_POS))     type_o[15:8] <= byte_i;
      if (pos == CNT_W'(TYPE_POS + 1)) type_o[7:0]  <= byte_i;
      if (pos == CNT_W'(TYPE_POS + 2)) tci_hi_q     <= byte_i;
    end
  end

endmodule

// File: rtl/vlan_filt_match.sv
module vlan_filt_match
  import vlan_filt_pkg::*;
#(
  parameter int HASH_N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eval_i,
  input  logic [15:0]       type_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  vlan_cfg_t         cfg_i,
  input  logic [HASH_N-1:0] hash_i,
  output logic              valid_o,
  output logic              tagged_o,
  output logic              match_o
);

  localparam int IDX_W = $clog2(HASH_N);

  logic [TAG_W-1:0] key, ref_tag;
  logic [31:0]      crc;
  logic [IDX_W-1:0] idx;
  logic             is_tag, hit;

  always_comb begin
    key     = tag_i;
    ref_tag = cfg_i.tag;
    if (cfg_i.vid_only) begin
      key[TAG_W-1:VID_W]     = '0;
      ref_tag[TAG_W-1:VID_W] = '0;
    end
    crc    = crc_tag(key);
    idx    = crc[31 -: IDX_W];
    is_tag = (type_i == ETH_C_TAG) || (cfg_i.svlan_en && type_i == ETH_S_TAG);
    hit    = cfg_i.hash_en ? hash_i[idx] : ((key == ref_tag) ^ cfg_i.inv_en);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      tagged_o <= 1'b0;
      match_o  <= 1'b0;
    end else begin
      valid_o  <= eval_i;
      tagged_o <= eval_i && is_tag;
      match_o  <= eval_i && is_tag && hit;
    end
  end

endmodule

// File: rtl/vlan_rx_filter.sv
module vlan_rx_filter
  import vlan_filt_pkg::*;
#(
  parameter int TYPE_POS = 12,
  parameter int HASH_N   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             sof_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic             res_valid_o,
  output logic             tagged_o,
  output logic             match_o
);

  vlan_cfg_t         act_cfg;
  logic [HASH_N-1:0] act_hash;
  logic              frame_start, last_byte;
  logic [15:0]       type_f, tag_f;

  vlan_filt_cfg #(.HASH_N(HASH_N)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .snap_i     (frame_start),
    .act_cfg_o  (act_cfg),
    .act_hash_o (act_hash)
  );

  vlan_filt_parse #(.TYPE_POS(TYPE_POS)) u_parse (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sof_i         (sof_i),
    .byte_valid_i  (byte_valid_i),
    .byte_i        (byte_i),
    .frame_start_o (frame_start),
    .last_o        (last_byte),
    .type_o        (type_f),
    .tag_o         (tag_f)
  );

  vlan_filt_match #(.HASH_N(HASH_N)) u_match (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .eval_i   (last_byte),
    .type_i   (type_f),
    .tag_i    (tag_f),
    .cfg_i    (act_cfg),
    .hash_i   (act_hash),
    .valid_o  (res_valid_o),
    .tagged_o (tagged_o),
    .match_o  (match_o)
  );

endmodule

// File: rtl/vlan_rx_filter_chk.sv
module vlan_rx_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sof_i,
  input logic byte_valid_i,
  input logic res_valid_o,
  input logic tagged_o,
  input logic match_o
);

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o); // R4

  AST_PULSE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(byte_valid_i)); // R4

  AST_QUIET_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> (!tagged_o && !match_o)); // R4

  AST_UNTAGGED_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !tagged_o) |-> !match_o); // R3

  AST_START_NO_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && sof_i) |=> !res_valid_o); // R10

endmodule

bind vlan_rx_filter vlan_rx_filter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sof_i        (sof_i),
  .byte_valid_i (byte_valid_i),
  .res_valid_o  (res_valid_o),
  .tagged_o     (tagged_o),
  .match_o      (match_o)
);

// File: tb/vlan_rx_filter_tb.sv
module vlan_rx_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic        sof = 1'b0, bv = 1'b0;
  logic [7:0]  bdat = '0;
  logic        res_v, res_t, res_m;

  int checks = 0, fails = 0, n_res = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vlan_rx_filter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .sof_i(sof), .byte_valid_i(bv), .byte_i(bdat),
    .res_valid_o(res_v), .tagged_o(res_t), .match_o(res_m)
  );

  // ---------- behavioural reference ----------
  function automatic logic [31:0] ref_crc(input logic [15:0] t);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  b;
    for (int k = 0; k < 16; k++) begin
      b = (k < 8) ? t[15:8] : t[7:0];
      if (c[0] ^ b[k % 8]) c = (c >> 1) ^ 32'hEDB88320;
      else                 c = c >> 1;
    end
    return ~c;
  endfunction

  function automatic int ref_idx(input logic [15:0] t, input bit vid);
    logic [31:0] c;
    c = ref_crc(vid ? {4'h0, t[11:0]} : t);
    return int'(c[31:28]);
  endfunction

  logic [19:0] m_ctl, a_ctl;
  logic [15:0] m_hash, a_hash;
  logic [7:0]  fb [16];
  int          m_cnt = 99;
  bit          e_v, e_t, e_m;
  string       m_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; a_ctl = 0; m_hash = 0; a_hash = 0; m_cnt = 99;
      e_v = 0; e_t = 0; e_m = 0;
    end else begin
      int p;
      e_v = 0; e_t = 0; e_m = 0;
      if (bv) begin
        p = sof ? 0 : m_cnt;
        if (sof) begin a_ctl = m_ctl; a_hash = m_hash; end
        if (p <= 15) begin
          fb[p] = bdat;
          m_cnt = p + 1;
          if (p == 15) begin
            logic [15:0] ty, tg, k1, k2;
            ty = {fb[12], fb[13]};
            tg = {fb[14], fb[15]};
            e_v = 1;
            e_t = (ty == 16'h8100) || (a_ctl[18] && ty == 16'h88A8);
            k1 = a_ctl[16] ? {4'h0, tg[11:0]} : tg;
            k2 = a_ctl[16] ? {4'h0, a_ctl[11:0]} : a_ctl[15:0];
            if (a_ctl[19]) e_m = e_t && a_hash[ref_idx(tg, a_ctl[16])];
            else           e_m = e_t && ((k1 == k2) != a_ctl[17]);
            m_req = !e_t ? "R3" : a_ctl[19] ? "R7" : a_ctl[17] ? "R6" : "R5";
          end
        end
      end
      if (cfg_we) begin
        if (cfg_sel) m_hash = cfg_wdata[15:0];
        else         m_ctl  = cfg_wdata;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  bit got_v, got_t, got_m;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if ({res_v, res_t, res_m} !== {e_v, e_t, e_m}) begin
        fails++;
        $display("FAIL %s per-cycle: actual v/t/m=%b%b%b expected=%b%b%b", m_req,
                 res_v, res_t, res_m, e_v, e_t, e_m);
      end
      if (res_v) begin got_v = 1; got_t = res_t; got_m = res_m; n_res++; end
    end
  end

  // ---------- helpers ----------
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input bit sel, input logic [19:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic [15:0] ty, input logic [15:0] tg, input int len, input bit gaps);
    for (int i = 0; i < len; i++) begin
      if (gaps && i % 3 == 1) begin @(negedge clk); bv = 0; sof = 0; end
      @(negedge clk);
      bv = 1; sof = (i == 0);
      bdat = (i == 12) ? ty[15:8] : (i == 13) ? ty[7:0] :
             (i == 14) ? tg[15:8] : (i == 15) ? tg[7:0] : 8'(i) ^ 8'h5A;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); bv = 0; sof = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input string req, input logic [15:0] ty, input logic [15:0] tg,
                       input int et, input int em);
    got_v = 0;
    send(ty, tg, 16, 0);
    idle(2);
    chk(req, got_v, 1);
    chk(req, got_t, et);
    chk(req, got_m, em);
  endtask

  task automatic finish_run;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  // ---------- stimulus ----------
  initial begin
    int ix, cnt0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {res_v, res_t, res_m}, 0);
    rst_n = 1;
    // R10: stray bytes before any frame start give nothing
    got_v = 0;
    repeat (20) begin @(negedge clk); bv = 1; bdat = 8'h81; end
    idle(2);
    chk("R10 pre-sof bytes", got_v, 0);
    frame("R1 default cfg", 16'h8100, 16'h0000, 1, 1);
    frame("R2 ctag tag mismatch", 16'h8100, 16'h0001, 1, 0);
    // R5 exact compare
    cfg_wr(0, 20'h02ABC);
    frame("R5 equal", 16'h8100, 16'h2ABC, 1, 1);
    frame("R5 top nibble differs", 16'h8100, 16'h3ABC, 1, 0);
    cfg_wr(0, 20'h12ABC);
    frame("R5 vid only", 16'h8100, 16'h3ABC, 1, 1);
    frame("R5 vid only miss", 16'h8100, 16'h3ABD, 1, 0);
    // R6 inverse
    cfg_wr(0, 20'h22ABC);
    frame("R6 inverse equal", 16'h8100, 16'h2ABC, 1, 0);
    frame("R6 inverse differ", 16'h8100, 16'h2ABD, 1, 1);
    // R3 type decode
    frame("R3 stag off", 16'h88A8, 16'h2ABD, 0, 0);
    frame("R3 ipv4 inverse", 16'h0800, 16'h2ABD, 0, 0);
    cfg_wr(0, 20'h42ABC);
    frame("R3 stag on", 16'h88A8, 16'h2ABC, 1, 1);
    frame("R3 other type", 16'h86DD, 16'h2ABC, 0, 0);
    // R7 / R8 hash
    ix = ref_idx(16'hF123, 0);
    cfg_wr(1, 20'(16'h1 << ix));
    cfg_wr(0, 20'h80000);
    frame("R7 hash hit", 16'h8100, 16'hF123, 1, 1);
    cfg_wr(1, 20'(~(16'h1 << ix)));
    frame("R7 hash miss", 16'h8100, 16'hF123, 1, 0);
    cfg_wr(0, 20'hA0000);
    frame("R7 inverse ignored", 16'h8100, 16'hF123, 1, 0);
    ix = ref_idx(16'h0123, 1);
    cfg_wr(1, 20'(16'h1 << ix));
    cfg_wr(0, 20'h90000);
    frame("R7 vid hash", 16'h8100, 16'hF123, 1, 1);
    cfg_wr(1, 20'hF0000);
    frame("R8 table from low bits", 16'h8100, 16'hF123, 1, 0);
    // R9 write during a frame
    cfg_wr(0, 20'h02ABC);
    got_v = 0;
    fork
      send(16'h8100, 16'h2ABC, 16, 0);
      begin repeat (6) @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = 20'h00000;
            @(negedge clk); cfg_we = 0; end
    join
    idle(2);
    chk("R9 mid-frame write", got_m, 1);
    got_v = 0;
    fork
      send(16'h8100, 16'h2ABC, 16, 0);
      begin @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = 20'h02ABC;
            @(negedge clk); cfg_we = 0; end
    join
    idle(2);
    chk("R9 write at sof", got_m, 0);
    frame("R9 applied next frame", 16'h8100, 16'h2ABC, 1, 1);
    // R4 short frame, R10 gaps / back-to-back / restart
    got_v = 0;
    send(16'h8100, 16'h2ABC, 15, 0);
    idle(3);
    chk("R4 short frame", got_v, 0);
    got_v = 0;
    send(16'h8100, 16'h2ABC, 16, 1);
    idle(2);
    chk("R10 gaps", got_m, 1);
    cnt0 = n_res;
    send(16'h8100, 16'h2ABC, 16, 0);
    send(16'h8100, 16'h2ABD, 16, 0);
    idle(2);
    chk("R10 back-to-back count", n_res - cnt0, 2);
    chk("R10 back-to-back second", got_m, 0);
    cnt0 = n_res;
    send(16'h0800, 16'h0000, 9, 0);
    send(16'h8100, 16'h2ABC, 16, 0);
    idle(2);
    chk("R10 restart count", n_res - cnt0, 1);
    chk("R10 restart match", got_m, 1);
    finish_run();
  end

endmodule